// File: doc/BRIEF.md
# Multichannel DAC Setup Sequencer

This controller brings a serially programmed four-channel converter out of power-on and later changes the output range of one channel at a time. It does not drive any wires itself. It issues 24-bit register write commands, one after another, to a downstream serial shift engine over a valid/ready port. The engine returns a done pulse once each word has been shifted out.

A bring-up request runs the following commands in order:

1. A reset command.
2. One supply-configuration write.
3. A control write for every channel, with the output left disabled.
4. A data write for every channel.
5. A timed settling wait, which lets the converter finish its internal calibration.
6. A second control write for every channel, which turns the output on.

A range-change request on a bring-up'd part runs four commands on the selected channel:

1. Park the output at the zero point of its present range.
2. Write the control register with the new range and the output off.
3. Write the new data value.
4. After the same settling wait, rewrite the control register with the output on.

Status outputs report busy, a completion pulse, a rejection flag and which channels have their output enabled.

Top module: `dac_setup_seq`

## Requirements
- R1: While and after a synchronous reset, `busy`, `done`, `err`, `cmd_valid` and every bit of `chan_enabled` are low.
- R2: A bring-up issues exactly 14 commands in this order:
  - a reset command (select 7, payload 0x0001);
  - a supply write (select 2) carrying the `SUPPLY_CFG` parameter;
  - control writes to channels 0..3 with output-enable clear;
  - data writes of `data_code` to channels 0..3;
  - control writes to channels 0..3 with output-enable set.
- R3: Every control write payload holds:
  - the range in bits [2:0];
  - internal-enable = 1 in bit 3;
  - supply-enable = 1 in bit 4;
  - output-enable in bit 5;
  - all other bits zero.
- R4: Each command word is laid out as select in [23:21], channel in [20:19], zero in [18:16] and payload in [15:0]. The select codes are 0 = data, 1 = control, 2 = supply, 7 = reset.
- R5: At least SETTLE = ceil(CLK_HZ x 200 / 1e6) clock cycles pass between the done pulse of the last data write and the rise of `cmd_valid` for the following enable write. This holds in both sequences.
- R6: The command port holds its word:
  - `cmd_valid` stays high with a stable `cmd_word` until `cmd_ready` is seen;
  - no new command is presented until `cmd_done` has pulsed for the previous one.
- R7: A range change on channel c issues exactly four commands:
  - a data write of the zero point of c's previous range (0x8000 when bit 2 of that range code is 1, else 0x0000);
  - a control write with the new range and output-enable clear;
  - a data write of `data_code`;
  - a control write with output-enable set.
  
  No supply write is issued.
- R8: A start strobe of either kind that arrives while `busy` is high is ignored. It leaves the command stream and the latched range and data unchanged.
- R9: A range-change request before a bring-up has completed issues no command, keeps `busy` low and sets `err`. The next accepted start clears `err`.
- R10: Bits of `chan_enabled` change as follows:
  - a channel's bit sets when its enable write completes;
  - during a range change the bit clears once the disabling control write completes;
  - `done` pulses for one cycle as `busy` falls at the end of each sequence.
- R11: A synchronous reset asserted mid-sequence returns the block to idle, with `busy` low, `cmd_valid` low and all channels marked not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bringup_start | input | 1 | Strobe: run the full power-on sequence |
| range_start | input | 1 | Strobe: change range of `chan_sel` |
| chan_sel | input | CH_W | Channel for a range change |
| range_code | input | 3 | Range to program, latched at start |
| data_code | input | 16 | Data value to program, latched at start |
| cmd_valid | output | 1 | Command word is presented |
| cmd_word | output | 24 | Register write command |
| cmd_ready | input | 1 | Shift engine accepts the word |
| cmd_done | input | 1 | Shift engine finished the accepted word |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| err | output | 1 | Range change requested before bring-up |
| chan_enabled | output | NCH | Per-channel output-enabled state |

## Verification
The assertions assume the following about the shift engine:
- it raises `cmd_ready` only while `cmd_valid` is high;
- it pulses `cmd_done` exactly once per accepted word, after `cmd_valid` has dropped.

They also assume the start strobes are single-cycle pulses. The bench's engine model enforces these assumptions. It waits zero to two extra cycles before each ready, holds done for one cycle two edges later, and drives strobes for exactly one cycle away from the clock edge. It does raise strobes while busy, but only to confirm that they are ignored.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    SEL_DATA   = 3'd0,
    SEL_CTRL   = 3'd1,
    SEL_SUPPLY = 3'd2,
    SEL_RESET  = 3'd7
  } sel_e;

  localparam int          CMD_W     = 24;
  localparam logic [15:0] RESET_KEY = 16'h0001;

  // word layout: select[23:21] channel[20:19] zero[18:16] payload[15:0]
  function automatic logic [CMD_W-1:0] mk_cmd(sel_e s, logic [1:0] ch, logic [15:0] pl);
    return {s, ch, 3'b000, pl};
  endfunction

  // control payload: range[2:0], internal-enable[3], supply-enable[4], output-enable[5]
  function automatic logic [15:0] ctrl_payload(logic [2:0] rng, logic oe);
    return {10'b0, oe, 1'b1, 1'b1, rng};
  endfunction

  // bipolar ranges (bit 2 set) rest at midscale, unipolar at zero scale
  function automatic logic [15:0] zero_point(logic [2:0] rng);
    return rng[2] ? 16'h8000 : 16'h0000;
  endfunction

endpackage

// File: rtl/dac_seq_settle.sv
module dac_seq_settle #(
  parameter int unsigned CYC = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int W = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        run <= 1'b1;
        cnt <= W'(CYC - 1);
      end else if (run) begin
        if (cnt == '0) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= W'(CYC - 1)));
  p_expire_after_run_r5: assert property (@(posedge clk) disable iff (rst)
    expired |-> $past(run));
  p_start_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> !run);

endmodule

// File: rtl/dac_seq_cmd_port.sv
module dac_seq_cmd_port
  import dac_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             send,
  input  logic [CMD_W-1:0] word_in,
  output logic             ack,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_ready,
  input  logic             cmd_done
);
  typedef enum logic [1:0] {P_IDLE, P_HOLD, P_WAIT} pst_e;
  pst_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= P_IDLE;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
      ack       <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st)
        P_IDLE: if (send) begin
          cmd_word  <= word_in;
          cmd_valid <= 1'b1;
          st        <= P_HOLD;
        end
        P_HOLD: if (cmd_ready) begin
          cmd_valid <= 1'b0;
          st        <= P_WAIT;
        end
        P_WAIT: if (cmd_done) begin
          ack <= 1'b1;
          st  <= P_IDLE;
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  p_hold_word_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));
  p_send_only_idle_r6: assert property (@(posedge clk) disable iff (rst)
    send |-> (st == P_IDLE));

endmodule

// File: rtl/dac_setup_seq.sv
module dac_setup_seq
  import dac_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned SETTLE_US  = 200,
  parameter int          NCH        = 4,
  parameter logic [15:0] SUPPLY_CFG = 16'h0123,
  localparam int         CH_W       = (NCH < 2) ? 1 : $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bringup_start,
  input  logic             range_start,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [2:0]       range_code,
  input  logic [15:0]      data_code,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_ready,
  input  logic             cmd_done,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [NCH-1:0]   chan_enabled
);
  localparam int unsigned SETTLE_CYC =
    32'((64'(CLK_HZ) * 64'(SETTLE_US) + 64'd999_999) / 64'd1_000_000);

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_SUP, S_CTRL0, S_DATA, S_SETTLE, S_CTRL1,
    S_RZERO, S_RCTRL0, S_RDATA, S_RSETTLE, S_RCTRL1
  } st_e;

  st_e              st;
  logic             pend;
  logic [CH_W-1:0]  ch_q;
  logic [2:0]       rng_lat;
  logic [15:0]      data_lat;
  logic [2:0]       range_q [NCH];
  logic             bring_ok;
  logic             send, ack, expired, tmr_start, last_ch, cmd_state;
  logic [CMD_W-1:0] word;

  assign last_ch   = (ch_q == CH_W'(NCH - 1));
  assign cmd_state = !(st inside {S_IDLE, S_SETTLE, S_RSETTLE});
  assign send      = cmd_state && !pend;
  assign tmr_start = ack && ((st == S_DATA && last_ch) || st == S_RDATA);

  always_comb begin
    case (st)
      S_RST:    word = mk_cmd(SEL_RESET, 2'd0, RESET_KEY);
      S_SUP:    word = mk_cmd(SEL_SUPPLY, 2'd0, SUPPLY_CFG);
      S_CTRL0,
      S_RCTRL0: word = mk_cmd(SEL_CTRL, 2'(ch_q), ctrl_payload(rng_lat, 1'b0));
      S_DATA,
      S_RDATA:  word = mk_cmd(SEL_DATA, 2'(ch_q), data_lat);
      S_CTRL1,
      S_RCTRL1: word = mk_cmd(SEL_CTRL, 2'(ch_q), ctrl_payload(rng_lat, 1'b1));
      S_RZERO:  word = mk_cmd(SEL_DATA, 2'(ch_q), zero_point(range_q[ch_q]));
      default:  word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      pend         <= 1'b0;
      ch_q         <= '0;
      rng_lat      <= '0;
      data_lat     <= '0;
      bring_ok     <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      chan_enabled <= '0;
      for (int i = 0; i < NCH; i++) range_q[i] <= '0;
    end else begin
      done <= 1'b0;
      if (ack)       pend <= 1'b0;
      else if (send) pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (bringup_start) begin
            st           <= S_RST;
            busy         <= 1'b1;
            err          <= 1'b0;
            rng_lat      <= range_code;
            data_lat     <= data_code;
            chan_enabled <= '0;
            bring_ok     <= 1'b0;
            ch_q         <= '0;
          end else if (range_start) begin
            if (bring_ok) begin
              st       <= S_RZERO;
              busy     <= 1'b1;
              err      <= 1'b0;
              ch_q     <= chan_sel;
              rng_lat  <= range_code;
              data_lat <= data_code;
            end else begin
              err <= 1'b1;
            end
          end
        end
        S_RST: if (ack) st <= S_SUP;
        S_SUP: if (ack) begin
          st   <= S_CTRL0;
          ch_q <= '0;
        end
        S_CTRL0: if (ack) begin
          range_q[ch_q] <= rng_lat;
          if (last_ch) begin
            ch_q <= '0;
            st   <= S_DATA;
          end else ch_q <= ch_q + CH_W'(1);
        end
        S_DATA: if (ack) begin
          if (last_ch) begin
            ch_q <= '0;
            st   <= S_SETTLE;
          end else ch_q <= ch_q + CH_W'(1);
        end
        S_SETTLE: if (expired) st <= S_CTRL1;
        S_CTRL1: if (ack) begin
          chan_enabled[ch_q] <= 1'b1;
          if (last_ch) begin
            st       <= S_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            bring_ok <= 1'b1;
          end else ch_q <= ch_q + CH_W'(1);
        end
        S_RZERO: if (ack) st <= S_RCTRL0;
        S_RCTRL0: if (ack) begin
          chan_enabled[ch_q] <= 1'b0;
          range_q[ch_q]      <= rng_lat;
          st                 <= S_RDATA;
        end
        S_RDATA:   if (ack) st <= S_RSETTLE;
        S_RSETTLE: if (expired) st <= S_RCTRL1;
        S_RCTRL1: if (ack) begin
          chan_enabled[ch_q] <= 1'b1;
          st                 <= S_IDLE;
          busy               <= 1'b0;
          done               <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  dac_seq_cmd_port u_port (
    .clk      (clk),
    .rst      (rst),
    .send     (send),
    .word_in  (word),
    .ack      (ack),
    .cmd_valid(cmd_valid),
    .cmd_word (cmd_word),
    .cmd_ready(cmd_ready),
    .cmd_done (cmd_done)
  );

  dac_seq_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .start  (tmr_start),
    .expired(expired)
  );

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid);
  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_reject_early_range_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !bringup_start && range_start && !bring_ok) |=> (!busy && err));
  p_enable_after_wait_r5: assert property (@(posedge clk) disable iff (rst)
    (st inside {S_SETTLE, S_RSETTLE} && !expired) |=> (st inside {S_SETTLE, S_RSETTLE}));

endmodule

// File: tb/dac_setup_seq_tb.sv
module dac_setup_seq_tb;
  localparam int unsigned HZ  = 1_234_567;
  localparam int unsigned EXP_SETTLE = (HZ * 200 + 999_999) / 1_000_000;
  localparam logic [15:0] SUP = 16'h5A3C;
  // vector: channel[20:19], new range[18:16], data[15:0]
  localparam logic [20:0] VEC [5] = '{
    {2'd1, 3'b000, 16'hABCD},
    {2'd1, 3'b110, 16'h0F0F},
    {2'd3, 3'b010, 16'hFFFF},
    {2'd0, 3'b100, 16'h0000},
    {2'd1, 3'b001, 16'h5555}
  };

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic bup = 1'b0, rch = 1'b0;
  logic [1:0] csel = '0;
  logic [2:0] rcode = '0;
  logic [15:0] dcode = '0;
  logic cmd_valid, cmd_ready = 1'b0, cmd_done = 1'b0;
  logic [23:0] cmd_word;
  logic busy, done, err;
  logic [3:0] chan_en;

  dac_setup_seq #(.CLK_HZ(HZ), .NCH(4), .SUPPLY_CFG(SUP)) u_dut (
    .clk(clk), .rst(rst), .bringup_start(bup), .range_start(rch),
    .chan_sel(csel), .range_code(rcode), .data_code(dcode),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .cmd_done(cmd_done), .busy(busy), .done(done), .err(err),
    .chan_enabled(chan_en)
  );

  int nvec = 0, nmis = 0;
  logic [23:0] lw [64];
  time tv [64], td [64];
  int log_n = 0, eng_st = 0, hold = 0, stab_bad = 0;

  // shift engine model
  always @(negedge clk) begin
    if (rst) begin
      eng_st = 0; cmd_ready = 1'b0; cmd_done = 1'b0;
    end else begin
      case (eng_st)
        0: if (cmd_valid && log_n < 64) begin
          lw[log_n] = cmd_word; tv[log_n] = $time; hold = log_n % 3;
          if (hold == 0) begin cmd_ready = 1'b1; eng_st = 2; end else eng_st = 1;
        end
        1: begin
          if (!cmd_valid || cmd_word !== lw[log_n]) stab_bad++;
          hold--;
          if (hold == 0) begin cmd_ready = 1'b1; eng_st = 2; end
        end
        2: begin
          cmd_ready = 1'b0;
          if (cmd_valid) stab_bad++;
          eng_st = 3;
        end
        3: begin
          if (cmd_valid) stab_bad++;
          cmd_done = 1'b1; td[log_n] = $time; log_n++; eng_st = 4;
        end
        default: begin cmd_done = 1'b0; eng_st = 0; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  function automatic logic [23:0] cw(input logic [2:0] s, input logic [1:0] c, input logic [15:0] p);
    return {s, c, 3'b000, p};
  endfunction

  function automatic logic [15:0] ctl(input logic [2:0] r, input logic oe);
    return {10'b0, oe, 1'b1, 1'b1, r};
  endfunction

  task automatic wait_log(input int n);
    int g = 0;
    while (log_n < n && g < 3000) begin tick(1); g++; end
    chk(log_n >= n, "R6 command stream stalled", 32'(log_n), 32'(n));
  endtask

  task automatic wait_done();
    int g = 0;
    while (!done && g < 3000) begin tick(1); g++; end
    chk(done === 1'b1, "R10 done pulse", 32'(done), 32'd1);
  endtask

  task automatic pulse_range(input logic [1:0] c, input logic [2:0] r, input logic [15:0] d);
    csel = c; rcode = r; dcode = d; rch = 1'b1; tick(1); rch = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nmis++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    logic [2:0] mrng [4];
    logic [20:0] v;
    logic [1:0] vc;
    logic [2:0] vr;
    logic [15:0] vd, z;
    int base, gap;

    tick(3);
    // R1 reset state
    chk(busy === 0 && done === 0 && err === 0 && cmd_valid === 0 && chan_en === 0,
        "R1 reset outputs", {busy, done, err, cmd_valid, chan_en}, 32'd0);
    rst = 1'b0;
    tick(2);

    // R9 range change before bring-up
    pulse_range(2'd2, 3'b001, 16'h1111);
    tick(1);
    chk(err === 1'b1 && busy === 1'b0, "R9 early range rejected", {err, busy}, 32'b10);
    tick(20);
    chk(log_n == 0, "R9 no command issued", 32'(log_n), 32'd0);

    // R2 bring-up
    rcode = 3'b101; dcode = 16'h1234; bup = 1'b1; tick(1); bup = 1'b0;
    tick(1);
    chk(err === 1'b0 && busy === 1'b1, "R9 err cleared on accepted start", {err, busy}, 32'b01);
    wait_log(3);
    // R8 strobes while busy
    rcode = 3'b011; dcode = 16'hFFFF; csel = 2'd2; bup = 1'b1; rch = 1'b1; tick(1);
    bup = 1'b0; rch = 1'b0;
    wait_done();
    tick(1);
    chk(lw[0] == cw(3'd7, 2'd0, 16'h0001), "R2 reset command", lw[0], cw(3'd7, 2'd0, 16'h0001));
    chk(lw[1] == cw(3'd2, 2'd0, SUP), "R2 supply config", lw[1], cw(3'd2, 2'd0, SUP));
    for (int c = 0; c < 4; c++) begin
      chk(lw[2+c] == cw(3'd1, 2'(c), ctl(3'b101, 1'b0)), "R3 first control write",
          lw[2+c], cw(3'd1, 2'(c), ctl(3'b101, 1'b0)));
      chk(lw[6+c] == cw(3'd0, 2'(c), 16'h1234), "R4 data write",
          lw[6+c], cw(3'd0, 2'(c), 16'h1234));
      chk(lw[10+c] == cw(3'd1, 2'(c), ctl(3'b101, 1'b1)), "R2 enable control write",
          lw[10+c], cw(3'd1, 2'(c), ctl(3'b101, 1'b1)));
      mrng[c] = 3'b101;
    end
    gap = int'((tv[10] - td[9]) / 8);
    chk(gap >= int'(EXP_SETTLE), "R5 bring-up settle", 32'(gap), EXP_SETTLE);
    tick(5);
    chk(log_n == 14, "R8 busy strobes ignored", 32'(log_n), 32'd14);
    chk(chan_en === 4'hF && busy === 1'b0, "R10 all enabled", {busy, chan_en}, 32'h0F);

    // range change vectors, R7
    for (int i = 0; i < 5; i++) begin
      v = VEC[i]; vc = v[20:19]; vr = v[18:16]; vd = v[15:0];
      z = mrng[vc][2] ? 16'h8000 : 16'h0000;
      base = log_n;
      pulse_range(vc, vr, vd);
      wait_log(base + 3);
      tick(5);
      chk(chan_en[vc] === 1'b0 && busy === 1'b1, "R10 channel disabled during change",
          {busy, chan_en}, 32'(vc));
      wait_done();
      tick(1);
      chk(lw[base] == cw(3'd0, vc, z), "R7 zero point", lw[base], cw(3'd0, vc, z));
      chk(lw[base+1] == cw(3'd1, vc, ctl(vr, 1'b0)), "R7 disable with new range",
          lw[base+1], cw(3'd1, vc, ctl(vr, 1'b0)));
      chk(lw[base+2] == cw(3'd0, vc, vd), "R7 new data", lw[base+2], cw(3'd0, vc, vd));
      chk(lw[base+3] == cw(3'd1, vc, ctl(vr, 1'b1)), "R7 re-enable",
          lw[base+3], cw(3'd1, vc, ctl(vr, 1'b1)));
      gap = int'((tv[base+3] - td[base+2]) / 8);
      chk(gap >= int'(EXP_SETTLE), "R5 range settle", 32'(gap), EXP_SETTLE);
      tick(3);
      chk(log_n == base + 4, "R7 exactly four commands", 32'(log_n), 32'(base + 4));
      chk(chan_en === 4'hF, "R10 channel re-enabled", 32'(chan_en), 32'hF);
      mrng[vc] = vr;
    end
    chk(stab_bad == 0, "R6 word held until ready, quiet until done", 32'(stab_bad), 32'd0);

    // R11 reset mid-sequence
    base = log_n;
    pulse_range(2'd2, 3'b011, 16'h2222);
    wait_log(base + 2);
    tick(4);
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
    chk(busy === 0 && cmd_valid === 0 && chan_en === 0 && done === 0,
        "R11 mid-sequence reset", {busy, cmd_valid, done, chan_en}, 32'd0);
    base = log_n;
    pulse_range(2'd0, 3'b000, 16'h3333);
    tick(20);
    chk(err === 1'b1 && log_n == base, "R9 range rejected after reset", {err, 8'(log_n - base)}, 32'h100);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

endmodule